// File: doc/BRIEF.md
# Word and Byte Load/Store Unit

This unit connects a 32-bit register datapath to a data memory that is addressed by byte. A request carries an operation code, a base register value, a signed 16-bit byte offset and store data. The unit adds the base and the sign-extended offset to form the effective address. It checks word accesses for alignment. It then drives a synchronous 32-bit memory port that has one write enable per byte lane, and it returns load results after sign or zero extension.

The memory answers a read one cycle after it sees the request. The unit remembers how the returned word must be treated: the whole word, or one byte lane extended with or without sign. It presents the result together with a valid strobe. A word access whose effective address is not a multiple of four never reaches memory. In its place the unit raises a one-cycle misalignment flag.

Top module: `ldst_unit`

## Requirements
- R1: The effective address is `base_i + sext32(offset_i)`, where `offset_i` is a 16-bit two's-complement value. An accepted access drives `mem_req_o` high in the same cycle, with `mem_addr_o` equal to the effective address with bits [1:0] cleared.
- R2: Operation codes on `op_i` are 0 word load, 1 word store, 2 signed byte load, 3 unsigned byte load and 4 byte store. Codes 5, 6 and 7 cause no memory request, no write enable, no load valid and no misalignment flag.
- R3: An aligned word load returns the full 32-bit memory word on `ld_data_o`, with byte k of the result (bits 8k+7:8k) taken from address EA+k.
- R4: A word load or word store whose effective address has bits [1:0] nonzero drives no `mem_req_o` and no write enables. It raises `misalign_o` for exactly the next cycle and produces no `ld_valid_o`.
- R5: A byte store asserts exactly one bit of `mem_we_o`, bit EA[1:0], at any alignment. Store data bits [7:0] appear in that lane of `mem_wdata_o`, and all other memory bytes keep their value.
- R6: A signed byte load returns the byte in lane EA[1:0] in bits [7:0], with bit 7 of that byte copied into bits [31:8].
- R7: An unsigned byte load returns the byte in lane EA[1:0] in bits [7:0], with bits [31:8] zero.
- R8: An aligned word store asserts all four write enables and drives `wdata_i` unchanged on `mem_wdata_o`, so byte k of the data lands at address EA+k.
- R9: `ld_valid_o` is high exactly one cycle after each accepted load request and low otherwise. After reset, `ld_valid_o` and `misalign_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed byte offset |
| wdata_i | input | 32 | Store data |
| mem_req_o | output | 1 | Memory access strobe |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_we_o | output | 4 | Per-byte write enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the request |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Misaligned word access flag |

## Verification
The memory-side outputs (`mem_req_o`, `mem_addr_o`, `mem_we_o`, `mem_wdata_o`) respond in the same cycle as the request. The bench drives a request on a falling edge and reads these outputs shortly after, before the next rising edge. The load result, its valid strobe and the misalignment flag are due one rising edge later, because each passes through one register or through the memory's one-cycle read. The bench reads them on the following falling edge and compares them against a byte-array model that it updates from the requirements.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned LANE_W  = $clog2(LANES);

  typedef enum logic [2:0] {
    OP_LDW  = 3'd0,
    OP_STW  = 3'd1,
    OP_LDB  = 3'd2,
    OP_LDBU = 3'd3,
    OP_STB  = 3'd4
  } ldst_op_e;

  typedef enum logic [1:0] {
    RSP_WORD   = 2'd0,
    RSP_BYTE_S = 2'd1,
    RSP_BYTE_U = 2'd2
  } rsp_kind_e;

  // Effective address: base plus sign-extended offset.
  function automatic logic [DATA_W-1:0] calc_ea(input logic [DATA_W-1:0] base,
                                                input logic [OFF_W-1:0]  off);
    logic [DATA_W-1:0] sext;
    sext = {{(DATA_W-OFF_W){off[OFF_W-1]}}, off};
    return base + sext;
  endfunction

  // Extend one byte to the full data width, with or without sign.
  function automatic logic [DATA_W-1:0] extend_byte(input logic [7:0] b,
                                                    input logic       is_signed);
    logic fill;
    fill = is_signed & b[7];
    return {{(DATA_W-8){fill}}, b};
  endfunction

  function automatic logic is_word_op(input logic [2:0] op);
    return (op == OP_LDW) || (op == OP_STW);
  endfunction

  function automatic logic is_load_op(input logic [2:0] op);
    return (op == OP_LDW) || (op == OP_LDB) || (op == OP_LDBU);
  endfunction

  function automatic logic is_known_op(input logic [2:0] op);
    return op <= OP_STB;
  endfunction
endpackage

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFF_W
) (
  input  logic          req_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  output logic [DW-1:0] ea_o,
  output logic          access_o,
  output logic          misalign_o
);
  localparam int unsigned LW = $clog2(DW / 8);

  logic known;
  logic word_op;
  logic off_lane;

  always_comb begin
    ea_o     = calc_ea(base_i, offset_i);
    known    = is_known_op(op_i);
    word_op  = is_word_op(op_i);
    off_lane = |ea_o[LW-1:0];
    misalign_o = req_i & word_op & off_lane;
    access_o   = req_i & known & ~misalign_o;
  end
endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
  import ldst_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic              access_i,
  input  logic [2:0]        op_i,
  input  logic [$clog2(DW/8)-1:0] lane_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW/8-1:0]   we_o,
  output logic [DW-1:0]     wdata_o
);
  localparam int unsigned NL = DW / 8;

  logic st_word;
  logic st_byte;

  assign st_word = access_i & (op_i == OP_STW);
  assign st_byte = access_i & (op_i == OP_STB);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic hit;
    assign hit = (lane_i == g[$clog2(NL)-1:0]);
    assign we_o[g] = st_word | (st_byte & hit);
    assign wdata_o[g*8 +: 8] = (op_i == OP_STW) ? wdata_i[g*8 +: 8] : wdata_i[7:0];
  end
endmodule

// File: rtl/ldst_load_align.sv
module ldst_load_align
  import ldst_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture_i,
  input  logic [2:0]               op_i,
  input  logic [$clog2(DW/8)-1:0]  lane_i,
  input  logic [DW-1:0]            rdata_i,
  output logic                     valid_o,
  output logic [DW-1:0]            data_o
);
  localparam int unsigned NL = DW / 8;
  localparam int unsigned LW = $clog2(NL);

  rsp_kind_e     kind_q;
  logic [LW-1:0] lane_q;
  logic [7:0]    byte_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      kind_q  <= RSP_WORD;
      lane_q  <= '0;
    end else begin
      valid_o <= capture_i;
      if (capture_i) begin
        lane_q <= lane_i;
        case (op_i)
          OP_LDB:  kind_q <= RSP_BYTE_S;
          OP_LDBU: kind_q <= RSP_BYTE_U;
          default: kind_q <= RSP_WORD;
        endcase
      end
    end
  end

  always_comb begin
    byte_sel = '0;
    for (int i = 0; i < NL; i++) begin
      if (lane_q == i[LW-1:0]) byte_sel = rdata_i[i*8 +: 8];
    end
    case (kind_q)
      RSP_BYTE_S: data_o = extend_byte(byte_sel, 1'b1);
      RSP_BYTE_U: data_o = extend_byte(byte_sel, 1'b0);
      default:    data_o = rdata_i;
    endcase
  end

  p_valid_follows_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> valid_o);
  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && kind_q == RSP_BYTE_U) |-> (data_o[DW-1:8] == '0));
  p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && kind_q == RSP_BYTE_S) |-> (data_o[DW-1:8] == {(DW-8){data_o[7]}}));
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  input  logic [DW-1:0] wdata_i,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW/8-1:0] mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          ld_valid_o,
  output logic [DW-1:0] ld_data_o,
  output logic          misalign_o
);
  localparam int unsigned LW = $clog2(DW / 8);

  logic [DW-1:0] ea;
  logic          access_evt;
  logic          misalign_evt;
  logic          load_fire;

  ldst_agu #(.DW(DW), .OW(OW)) agu_i (
    .req_i      (req_i),
    .op_i       (op_i),
    .base_i     (base_i),
    .offset_i   (offset_i),
    .ea_o       (ea),
    .access_o   (access_evt),
    .misalign_o (misalign_evt)
  );

  ldst_store_lanes #(.DW(DW)) st_i (
    .access_i (access_evt),
    .op_i     (op_i),
    .lane_i   (ea[LW-1:0]),
    .wdata_i  (wdata_i),
    .we_o     (mem_we_o),
    .wdata_o  (mem_wdata_o)
  );

  assign load_fire  = access_evt & is_load_op(op_i);
  assign mem_req_o  = access_evt;
  assign mem_addr_o = {ea[DW-1:LW], {LW{1'b0}}};

  ldst_load_align #(.DW(DW)) ld_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (load_fire),
    .op_i      (op_i),
    .lane_i    (ea[LW-1:0]),
    .rdata_i   (mem_rdata_i),
    .valid_o   (ld_valid_o),
    .data_o    (ld_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) misalign_o <= 1'b0;
    else        misalign_o <= misalign_evt;
  end

  p_misalign_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_evt |-> (!mem_req_o && mem_we_o == '0));
  p_misalign_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_evt |=> (misalign_o && !ld_valid_o));
  p_flag_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> $past(misalign_evt));
  p_byte_store_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && op_i == OP_STB) |-> ($countones(mem_we_o) == 1));
  p_word_store_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && op_i == OP_STW && !misalign_evt) |-> (&mem_we_o));
  p_unknown_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && op_i > OP_STB) |-> (!mem_req_o && mem_we_o == '0 && !misalign_evt));
endmodule

// File: tb/ldst_unit_tb_top.sv
module ldst_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] wdata_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic [3:0]  mem_we_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        ld_valid_o;
  logic [31:0] ld_data_o;
  logic        misalign_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mem [0:63];
  logic [7:0]  refm [0:255];

  always #2.5 clk = ~clk;

  ldst_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i), .base_i(base_i),
    .offset_i(offset_i), .wdata_i(wdata_i), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o),
    .misalign_o(misalign_o)
  );

  // Synchronous memory, one-cycle read latency.
  always @(posedge clk) begin
    if (mem_req_o) begin
      mem_rdata_i <= mem[mem_addr_o[7:2]];
      for (int k = 0; k < 4; k++)
        if (mem_we_o[k]) mem[mem_addr_o[7:2]][k*8 +: 8] <= mem_wdata_o[k*8 +: 8];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] op, input logic [31:0] base,
                        input logic [15:0] off, input logic [31:0] wd);
    logic [31:0] ea;
    logic [7:0]  a;
    logic [7:0]  b;
    bit          word, mis, known, load;
    logic [3:0]  exp_we;
    logic [31:0] exp_data;
    ea    = base + {{16{off[15]}}, off};
    a     = ea[7:0];
    word  = (op == 3'd0) || (op == 3'd1);
    known = op <= 3'd4;
    mis   = word && (ea[1:0] != 2'b00);
    load  = known && !mis && (op == 3'd0 || op == 3'd2 || op == 3'd3);
    exp_we = 4'h0;
    if (!mis && op == 3'd1) exp_we = 4'hF;
    if (op == 3'd4) exp_we = 4'b0001 << ea[1:0];
    b = refm[a];
    exp_data = '0;
    if (op == 3'd0) exp_data = {refm[a+8'd3], refm[a+8'd2], refm[a+8'd1], refm[a]};
    if (op == 3'd2) exp_data = {{24{b[7]}}, b};
    if (op == 3'd3) exp_data = {24'h0, b};

    @(negedge clk);
    req_i = 1'b1; op_i = op; base_i = base; offset_i = off; wdata_i = wd;
    #1;
    if (!known) begin
      check(!mem_req_o && mem_we_o == 0, "R2 idle on unused code", {31'b0, mem_req_o}, 32'h0);
    end else if (mis) begin
      check(!mem_req_o && mem_we_o == 0, "R4 no access when misaligned", {28'b0, mem_we_o}, 32'h0);
    end else begin
      check(mem_req_o && mem_addr_o == {ea[31:2], 2'b00}, "R1 address", mem_addr_o, {ea[31:2], 2'b00});
      if (op == 3'd1) begin
        check(mem_we_o == exp_we, "R8 word enables", {28'b0, mem_we_o}, {28'b0, exp_we});
        check(mem_wdata_o == wd, "R8 word data", mem_wdata_o, wd);
      end else if (op == 3'd4) begin
        check(mem_we_o == exp_we, "R5 byte enable", {28'b0, mem_we_o}, {28'b0, exp_we});
        check(mem_wdata_o[ea[1:0]*8 +: 8] == wd[7:0], "R5 byte lane data",
              {24'b0, mem_wdata_o[ea[1:0]*8 +: 8]}, {24'b0, wd[7:0]});
      end else begin
        check(mem_we_o == 4'h0, "R3 load writes nothing", {28'b0, mem_we_o}, 32'h0);
      end
    end
    // Reference update
    if (!mis && op == 3'd1)
      for (int k = 0; k < 4; k++) refm[a + k[7:0]] = wd[k*8 +: 8];
    if (op == 3'd4) refm[a] = wd[7:0];

    @(negedge clk);
    req_i = 1'b0;
    check(misalign_o == mis, "R4 misalign flag timing", {31'b0, misalign_o}, {31'b0, mis});
    check(ld_valid_o == load, "R9 load valid timing", {31'b0, ld_valid_o}, {31'b0, load});
    if (load) begin
      if (op == 3'd0) check(ld_data_o == exp_data, "R3 word load data", ld_data_o, exp_data);
      if (op == 3'd2) check(ld_data_o == exp_data, "R6 signed byte load", ld_data_o, exp_data);
      if (op == 3'd3) check(ld_data_o == exp_data, "R7 unsigned byte load", ld_data_o, exp_data);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int i = 0; i < 256; i++) refm[i] = '0;
    repeat (3) @(negedge clk);
    check(!ld_valid_o && !misalign_o, "R9 reset state", {30'b0, ld_valid_o, misalign_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ld_valid_o && !misalign_o, "R9 idle after reset", {30'b0, ld_valid_o, misalign_o}, 32'h0);

    // R8: fill every word; negative offsets from a base above the region
    for (int i = 0; i < 64; i++)
      access(3'd1, 32'h0000_0140, 16'(i*4 - 320), (i * 32'h0103_0507) ^ 32'h80A0_C0E0);
    // R3: read every word back
    for (int i = 0; i < 64; i++) access(3'd0, 32'h0, 16'(i*4), 32'h0);
    // R6, R7: every byte, both extensions
    for (int i = 0; i < 256; i++) begin
      access(3'd2, 32'h10, 16'(i - 16), 32'h0);
      access(3'd3, 32'h0, 16'(i), 32'h0);
    end
    // R5: byte stores at every lane, then reread words
    for (int i = 0; i < 64; i++) access(3'd4, 32'h0, 16'(i*5), 32'hFFFF_FF00 | 32'(i*37 + 3));
    for (int i = 0; i < 80; i++) access(3'd0, 32'h0, 16'((i % 64)*4), 32'h0);
    // R4: misaligned word accesses, memory untouched afterwards
    for (int i = 0; i < 16; i++)
      for (int s = 1; s < 4; s++) begin
        access(3'd1, 32'(i*4 + s), 16'h0, 32'hDEAD_BEEF);
        access(3'd0, 32'(i*4), 16'(s), 32'h0);
        access(3'd0, 32'(i*4), 16'h0, 32'h0);
      end
    // R2: unused codes do nothing, memory unchanged
    for (int c = 5; c < 8; c++) begin
      access(3'(c), 32'h8, 16'h0, 32'h1234_5678);
      access(3'd0, 32'h8, 16'h0, 32'h0);
    end
    // R1: offset wrap across the 16-bit sign boundary
    access(3'd1, 32'h0000_8020, 16'h8000, 32'hCAFE_F00D);
    access(3'd0, 32'h20, 16'h0, 32'h0);
    access(3'd2, 32'hFFFF_FFFF, 16'h0024, 32'h0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end
endmodule